// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block decides whether the chip clock comes from the on-die oscillator or from an external resonator, and it sequences the move from one to the other. Out of reset the internal oscillator (nominally 6 MHz) runs the chip and is also driven out on the crystal output pin. Software requests the external source by writing a configuration word with the external-enable bit set. The block then stops the chip clock and shuts the internal oscillator. It turns on the external oscillator and waits for that oscillator to report stable. When it does, the chip clock comes back, and the processor is held for a further resume delay that software selects.

The handover goes one way only. After the switch, clearing the enable bit does nothing. The chip returns to the internal oscillator only when a wake-from-suspend event arrives while the external source is running. All delays are counted in reference clock cycles at 6 MHz. The stable indication from the analog oscillator is asynchronous, so it passes through a two-flop synchronizer before the sequencer uses it.

Top module: `clksw_seq`

## Requirements
- R1: After reset the internal source is selected: `int_osc_en_o`=1, `ext_osc_en_o`=0, `chip_clk_en_o`=1, `cpu_run_o`=1, `xtalout_oe_o`=1.
- R2: While the internal source is selected, `xtalout_oe_o` is the inverse of configuration bit 1 (output disable) as last written. While it is not selected, `xtalout_oe_o` is 0.
- R3: A write with bit 0 set while the internal source is selected takes effect in the next cycle: `int_osc_en_o`=0, `ext_osc_en_o`=1, `chip_clk_en_o`=0, `cpu_run_o`=0.
- R4: While halted, the chip clock stays off for as long as `xtal_stable_i` is low. Once `xtal_stable_i` is high at a clock edge, `chip_clk_en_o` rises after the third edge counted from that one (two synchronizer flops, then the state register).
- R5: After the chip clock restarts, `cpu_run_o` stays low for exactly 768 cycles when configuration bit 7 was 0, or 24000 cycles when it was 1. Bit 7 is sampled when the clock restarts. After that `cpu_run_o` is 1.
- R6: Once the switch has started, a write to bit 0, whether it clears or sets the bit, has no effect on the source or on `cpu_run_o`.
- R7: A `wake_i` pulse while running from the external source returns the chip to the internal source in the next cycle, with the outputs of R1. A `wake_i` pulse while halted or in the resume delay is ignored.
- R8: `xtalin_gpio_o` follows `xtalin_pin_i` while the internal source is selected and is 0 otherwise. The block has no interrupt output for this pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 6 MHz reference clock |
| rst_n_i | input | 1 | Active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Write data: bit 0 external enable, bit 1 output disable, bit 7 long resume delay |
| xtal_stable_i | input | 1 | Asynchronous stable indication from the external oscillator |
| wake_i | input | 1 | Wake-from-suspend event |
| xtalin_pin_i | input | 1 | Level on the crystal input pin |
| int_osc_en_o | output | 1 | Internal oscillator enable |
| ext_osc_en_o | output | 1 | External oscillator enable |
| chip_clk_en_o | output | 1 | Chip clock gate enable |
| cpu_run_o | output | 1 | Processor release |
| xtalout_oe_o | output | 1 | Drive the internal clock onto the crystal output pin |
| xtalin_gpio_o | output | 1 | General-purpose input view of the crystal input pin |

## Verification
A wrong sequencer state shows at the oscillator enables and the clock gate in the very next cycle. For example, a missed transition leaves `chip_clk_en_o` low after the third edge that follows a stable indication. A resume counter loaded with the wrong value, or the wrong bit-7 choice, shows as a `cpu_run_o` rise that comes too early or too late; the bench counts the cycles between the clock restart and that rise. A sequencer that reacts to bit 0 or to wake in the wrong state shows within one cycle as a dropped `cpu_run_o` or a re-enabled internal oscillator.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic [1:0] {
        ST_INTERNAL  = 2'd0,
        ST_HALT_WAIT = 2'd1,
        ST_RESUME    = 2'd2,
        ST_EXT_RUN   = 2'd3
    } clksw_state_e;

    typedef struct packed {
        clksw_state_e state;
        logic         out_dis;
        logic         slow_resume;
    } clksw_regs_t;

    localparam int EXT_EN_BIT  = 0;
    localparam int OUT_DIS_BIT = 1;
    localparam int SLOW_BIT    = 7;

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_n_i) begin
                if (!rst_n_i) chain_q <= '0;
                else          chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i or negedge rst_n_i) begin
                if (!rst_n_i) chain_q <= '0;
                else          chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clksw_dly_cnt.sv
module clksw_dly_cnt #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic             done_o
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = load_val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cnt_q <= '0;
        else          cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
#(
    parameter int SHORT_DLY   = 768,
    parameter int LONG_DLY    = 24000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       cfg_wr_i,
    input  logic [7:0] cfg_wdata_i,
    input  logic       xtal_stable_i,
    input  logic       wake_i,
    input  logic       xtalin_pin_i,
    output logic       int_osc_en_o,
    output logic       ext_osc_en_o,
    output logic       chip_clk_en_o,
    output logic       cpu_run_o,
    output logic       xtalout_oe_o,
    output logic       xtalin_gpio_o
);
    localparam int CNT_W = $clog2(LONG_DLY + 1);

    clksw_regs_t      regs_d, regs_q;
    logic             stable_s;
    logic             cnt_load;
    logic             cnt_done;
    logic [CNT_W-1:0] cnt_val;
    logic             unused_wbits;

    assign unused_wbits = ^cfg_wdata_i[6:2];

    clksw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (xtal_stable_i),
        .q_o     (stable_s)
    );

    // Resume length picked by the stored delay-select bit at clock restart
    assign cnt_val = regs_q.slow_resume ? CNT_W'(LONG_DLY - 1) : CNT_W'(SHORT_DLY - 1);

    clksw_dly_cnt #(.WIDTH(CNT_W)) u_dly (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .done_o     (cnt_done)
    );

    always_comb begin
        regs_d   = regs_q;
        cnt_load = 1'b0;
        if (cfg_wr_i) begin
            regs_d.out_dis     = cfg_wdata_i[OUT_DIS_BIT];
            regs_d.slow_resume = cfg_wdata_i[SLOW_BIT];
        end
        unique case (regs_q.state)
            ST_INTERNAL: begin
                if (cfg_wr_i && cfg_wdata_i[EXT_EN_BIT]) regs_d.state = ST_HALT_WAIT;
            end
            ST_HALT_WAIT: begin
                if (stable_s) begin
                    regs_d.state = ST_RESUME;
                    cnt_load     = 1'b1;
                end
            end
            ST_RESUME: begin
                if (cnt_done) regs_d.state = ST_EXT_RUN;
            end
            ST_EXT_RUN: begin
                if (wake_i) regs_d.state = ST_INTERNAL;
            end
            default: regs_d.state = ST_INTERNAL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            regs_q.state       <= ST_INTERNAL;
            regs_q.out_dis     <= 1'b0;
            regs_q.slow_resume <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        int_osc_en_o  = (regs_q.state == ST_INTERNAL);
        ext_osc_en_o  = !int_osc_en_o;
        chip_clk_en_o = (regs_q.state != ST_HALT_WAIT);
        cpu_run_o     = (regs_q.state == ST_INTERNAL) || (regs_q.state == ST_EXT_RUN);
        xtalout_oe_o  = int_osc_en_o && !regs_q.out_dis;
        xtalin_gpio_o = int_osc_en_o && xtalin_pin_i;
    end
endmodule

// File: rtl/clksw_seq_chk.sv
module clksw_seq_chk #(
    parameter int SHORT_DLY = 768,
    parameter int LONG_DLY  = 24000
) (
    input logic       clk_i,
    input logic       rst_n_i,
    input logic       cfg_wr_i,
    input logic [7:0] cfg_wdata_i,
    input logic       xtal_stable_i,
    input logic       wake_i,
    input logic       int_osc_en_o,
    input logic       ext_osc_en_o,
    input logic       chip_clk_en_o,
    input logic       cpu_run_o,
    input logic       xtalout_oe_o,
    input logic       xtalin_gpio_o
);
    localparam int CW = $clog2(LONG_DLY + 2);
    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)                                       hold_cnt <= '0;
        else if (ext_osc_en_o && chip_clk_en_o && !cpu_run_o) hold_cnt <= hold_cnt + 1'b1;
        else if (!chip_clk_en_o)                            hold_cnt <= '0;
    end

    AST_OSC_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(int_osc_en_o && ext_osc_en_o)); // R3
    AST_SWITCH_START: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (int_osc_en_o && cfg_wr_i && cfg_wdata_i[0]) |=> (!chip_clk_en_o && ext_osc_en_o && !cpu_run_o)); // R3
    AST_OE_ONLY_INTERNAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !int_osc_en_o |-> !xtalout_oe_o); // R2
    AST_RESTART_AFTER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ext_osc_en_o && $rose(chip_clk_en_o)) |-> $past(xtal_stable_i, 3)); // R4
    AST_CPU_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cpu_run_o |-> chip_clk_en_o); // R5
    AST_RESUME_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ext_osc_en_o && $rose(cpu_run_o)) |-> (hold_cnt == CW'(SHORT_DLY) || hold_cnt == CW'(LONG_DLY))); // R5
    AST_NO_RESTART_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ext_osc_en_o && cpu_run_o && !wake_i) |=> (ext_osc_en_o && cpu_run_o)); // R6
    AST_BACK_ONLY_ON_WAKE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(int_osc_en_o) |-> $past(wake_i)); // R7
    AST_GPIO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ext_osc_en_o |-> !xtalin_gpio_o); // R8
endmodule

bind clksw_seq clksw_seq_chk #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) chk_i (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .xtal_stable_i (xtal_stable_i),
    .wake_i        (wake_i),
    .int_osc_en_o  (int_osc_en_o),
    .ext_osc_en_o  (ext_osc_en_o),
    .chip_clk_en_o (chip_clk_en_o),
    .cpu_run_o     (cpu_run_o),
    .xtalout_oe_o  (xtalout_oe_o),
    .xtalin_gpio_o (xtalin_gpio_o)
);

// File: tb/clksw_seq_tb.sv
module clksw_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SHORT_N    = 768;
    localparam int LONG_N     = 24000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       stable = 1'b0;
    logic       wake = 1'b0;
    logic       pin = 1'b0;
    logic       int_en, ext_en, clk_en, cpu_run, oe, gpio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksw_seq dut_i (
        .clk_i         (clk),
        .rst_n_i       (rst_n),
        .cfg_wr_i      (cfg_wr),
        .cfg_wdata_i   (cfg_wdata),
        .xtal_stable_i (stable),
        .wake_i        (wake),
        .xtalin_pin_i  (pin),
        .int_osc_en_o  (int_en),
        .ext_osc_en_o  (ext_en),
        .chip_clk_en_o (clk_en),
        .cpu_run_o     (cpu_run),
        .xtalout_oe_o  (oe),
        .xtalin_gpio_o (gpio)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // packs {int_en, ext_en, clk_en, cpu_run}
    function automatic int mode();
        return {int_en, ext_en, clk_en, cpu_run};
    endfunction

    task automatic wr(input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0; cfg_wdata = 8'h00;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode after reset", mode(), 4'b1011);
        chk("R1 xtalout drive after reset", oe, 1);
    endtask

    task automatic t_out_disable();
        wr(8'h02);
        chk("R2 output disabled", oe, 0);
        wr(8'h00);
        chk("R2 output re-enabled", oe, 1);
    endtask

    task automatic t_gpio_internal();
        pin = 1'b1; #1;
        chk("R8 gpio follows pin high", gpio, 1);
        pin = 1'b0; #1;
        chk("R8 gpio follows pin low", gpio, 0);
    endtask

    // Full switch; slow selects bit 7
    task automatic t_switch(input bit slow, input int exp_len);
        int n;
        wr(slow ? 8'h81 : 8'h01);
        chk("R3 halted after enable write", mode(), 4'b0100);
        chk("R2 no drive when not internal", oe, 0);
        pin = 1'b1; #1;
        chk("R8 gpio quiet in external mode", gpio, 0);
        pin = 1'b0;
        repeat (10) @(negedge clk);
        chk("R4 held halted without stable", clk_en, 0);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        chk("R7 wake ignored while halted", mode(), 4'b0100);
        stable = 1'b1;
        @(negedge clk);
        chk("R4 clock off one edge after stable", clk_en, 0);
        @(negedge clk);
        chk("R4 clock off two edges after stable", clk_en, 0);
        @(negedge clk);
        chk("R4 clock on three edges after stable", clk_en, 1);
        n = 0;
        while (cpu_run == 1'b0 && n < LONG_N + 100) begin
            n++;
            @(negedge clk);
        end
        chk(slow ? "R5 long resume length" : "R5 short resume length", n, exp_len);
        chk("R5 running external", mode(), 4'b0111);
    endtask

    task automatic t_ignore_bit0();
        wr(8'h00);
        chk("R6 clearing bit 0 keeps external", mode(), 4'b0111);
        wr(8'h01);
        chk("R6 setting bit 0 again no restart", mode(), 4'b0111);
        repeat (5) @(negedge clk);
        chk("R6 still running external", mode(), 4'b0111);
    endtask

    task automatic t_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        stable = 1'b0;
        chk("R7 back to internal on wake", mode(), 4'b1011);
        chk("R7 xtalout drive restored", oe, 1);
        pin = 1'b1; #1;
        chk("R8 gpio live again", gpio, 1);
        pin = 1'b0;
    endtask

    task automatic t_wake_in_resume();
        wr(8'h01);
        stable = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 in resume delay", mode(), 4'b0110);
        wake = 1'b1; @(negedge clk); wake = 1'b0;
        chk("R7 wake ignored in resume delay", mode(), 4'b0110);
        while (cpu_run == 1'b0) @(negedge clk);
        t_wake();
    endtask

    initial begin
        t_reset();
        t_out_disable();
        t_gpio_internal();
        t_switch(1'b0, SHORT_N);
        t_ignore_bit0();
        t_wake();
        t_switch(1'b1, LONG_N);
        t_wake();
        t_wake_in_resume();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule